// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block sits between a memory-mapped slave port and the request path of a serial fabric endpoint. Each incoming request carries a word address. The block scales that address to a byte address by shifting it left by N bits. N depends on the configured lane count: 2 for one lane, 3 for two or four lanes. The block then compares the shifted address against a small bank of programmable windows. Each window has a base, a mask, an offset and an enable bit.

The lowest-numbered enabled window that matches is chosen. The block builds the fabric address from that window's offset and from the shifted address. It adds a 2-bit extended-MSBs prefix taken from the bottom of the window's offset register. Every translated request also carries a priority and a destination ID from a shared control register.

A request that matches no window is dropped. A missed write sets a sticky write-miss status bit, and a missed read sets a sticky read-miss status bit. A missed write also advances a wrapping write-miss counter. Each status bit drives the interrupt output only when its enable bit is set. Software clears a status bit by writing 1 to it.

Top module: `win_addr_xlate`

## Requirements
- R1: After reset, all windows are disabled, out_valid is 0, both status bits are 0, the write-miss counter is 0 and irq is 0. The registers live on an 8-bit configuration bus: for window w, the base is at 4w, the mask at 4w+1, the offset at 4w+2 and the enable bit (bit 0) at 4w+3. The control register is at 0x80, with priority in bits [1:0] and destination ID in bits [31:16]. The status register is at 0x81, with bit 0 for write miss and bit 1 for read miss. The interrupt enable register is at 0x82, with the same bit positions as the status register.
- R2: The incoming word address is shifted left by N (2 for LANES=1, otherwise 3) with zero fill. Window w matches when it is enabled and (shifted & mask) == (base & mask). A disabled window never matches.
- R3: When several windows match, the lowest-numbered one is used.
- R4: out_addr[31:3] = (offset[31:3] & mask[31:3]) | shifted[31:3]. out_addr[33:32] = offset[1:0] of the selected window.
- R5: Bits [2:0] of the base and mask take no part in matching. Bits [2:0] of the offset take no part in forming out_addr[31:3].
- R6: out_prio and out_dest of a translated request equal the control register fields at the time the request is accepted.
- R7: A matching request produces exactly one output beat with out_valid=1 on the clock edge that samples the request. The beat carries out_write equal to req_write.
- R8: A request that matches no window produces no output beat. A missed write sets status bit 0 and a missed read sets status bit 1. Both bits stay set until cleared.
- R9: irq is 1 exactly when some status bit and its enable bit are both 1.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a clear and a new miss of the same kind happen on the same edge, the bit stays set.
- R11: Each missed write increments wr_miss_cnt by one, with wrap-around. Missed reads and translated requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Incoming request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 32-N (30 by default) | Incoming word address |
| out_valid | output | 1 | Translated request valid |
| out_write | output | 1 | Write/read flag of the translated request |
| out_addr | output | 31 ([33:3]) | Translated fabric address including extended MSBs |
| out_prio | output | PRIO_W (2) | Priority from the control register |
| out_dest | output | DEST_W (16) | Destination ID from the control register |
| sts_oob | output | 2 | Sticky miss status: bit 0 write, bit 1 read |
| wr_miss_cnt | output | CNT_W (16) | Count of missed writes |
| irq | output | 1 | Miss interrupt |

## Verification
The hardest case to reach from the ports is a status bit being cleared by software on the same edge that a new miss of that kind tries to set it. The bench produces this by driving a configuration write of 1 to the status register in the same cycle as a write request to an address known to miss every window. It then checks that the bit survives and that the counter still advances.

Window priority is also hard to reach, because it needs overlapping windows. The bench arranges this by sweeping addresses whose shifted top nibble covers all sixteen values. Two enabled windows overlap, one window starts disabled, and garbage is written into the low bits of the base, mask and offset registers.

// File: rtl/xlate_pkg.sv
// Shared types and register addresses for the windowed address translator.
// Assumes a 32-bit byte address space on the slave side.
package xlate_pkg;

    localparam int unsigned BYTE_AW = 32;

    // Fixed-position registers on the configuration bus
    localparam logic [7:0] CTRL_ADDR = 8'h80;
    localparam logic [7:0] STS_ADDR  = 8'h81;
    localparam logic [7:0] IEN_ADDR  = 8'h82;

    // Low bits of base/mask/offset that never take part in translation
    localparam logic [BYTE_AW-1:0] LOW_KEEP = ~32'h7;

    typedef struct packed {
        logic               en;
        logic [BYTE_AW-1:0] base;
        logic [BYTE_AW-1:0] mask;
        logic [BYTE_AW-1:0] offset;
    } win_cfg_t;

endpackage

// File: rtl/xlate_cfg_regs.sv
// Configuration register bank: per-window base/mask/offset/enable, the
// control register (priority, destination) and the interrupt enables.
// Decodes writes to the status register into a clear vector.
// Assumes NUM_WIN <= 32 so window registers stay below 0x80.
module xlate_cfg_regs
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned PRIO_W  = 2,
    parameter int unsigned DEST_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [7:0]                cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]    win,
    output logic [PRIO_W-1:0]         prio,
    output logic [DEST_W-1:0]         dest,
    output logic [1:0]                ien,
    output logic [1:0]                sts_clr
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [7:0] A_BASE = 8'(4 * w);
        localparam logic [7:0] A_MASK = 8'(4 * w + 1);
        localparam logic [7:0] A_OFFS = 8'(4 * w + 2);
        localparam logic [7:0] A_EN   = 8'(4 * w + 3);

        // Hold this window's four registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win[w] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == A_BASE) win[w].base   <= cfg_wdata;
                if (cfg_addr == A_MASK) win[w].mask   <= cfg_wdata;
                if (cfg_addr == A_OFFS) win[w].offset <= cfg_wdata;
                if (cfg_addr == A_EN)   win[w].en     <= cfg_wdata[0];
            end
        end
    end

    // Control register and interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio <= '0;
            dest <= '0;
            ien  <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CTRL_ADDR) begin
                prio <= cfg_wdata[PRIO_W-1:0];
                dest <= cfg_wdata[16 +: DEST_W];
            end
            if (cfg_addr == IEN_ADDR) ien <= cfg_wdata[1:0];
        end
    end

    // Write-one-to-clear request toward the status register
    always_comb begin
        sts_clr = (cfg_we && cfg_addr == STS_ADDR) ? cfg_wdata[1:0] : 2'b00;
    end

endmodule

// File: rtl/xlate_win_match.sv
// Compares a byte address against every window in parallel and forms the
// translated address from the lowest-numbered matching window.
// Purely combinational; assumes the caller registers the result.
module xlate_win_match
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4
) (
    input  win_cfg_t [NUM_WIN-1:0]    win,
    input  logic [BYTE_AW-1:0]        saddr,
    output logic                      hit,
    output logic [33:3]               xaddr
);

    logic [NUM_WIN-1:0]         hit_vec;
    logic [NUM_WIN-1:0][33:3]   cand;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic [BYTE_AW-1:0] m;
        logic [BYTE_AW-1:0] comb_addr;

        // Effective mask with the low bits forced out
        assign m = win[w].mask & LOW_KEEP;
        // Window compare, gated by the enable bit
        assign hit_vec[w] = win[w].en && ((saddr & m) == (win[w].base & m));
        // Masked offset merged with the shifted address
        assign comb_addr = (win[w].offset & m) | (saddr & LOW_KEEP);
        assign cand[w] = {win[w].offset[1:0], comb_addr[31:3]};
    end

    // Lowest index wins: scan from the top so index 0 is written last
    always_comb begin
        hit   = 1'b0;
        xaddr = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit   = 1'b1;
                xaddr = cand[w];
            end
        end
    end

endmodule

// File: rtl/xlate_miss_track.sv
// Sticky miss status with write-one-to-clear, enable-gated interrupt and a
// wrapping count of missed writes. A set and a clear on the same edge
// leave the bit set.
module xlate_miss_track #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss,
    input  logic             miss_write,
    input  logic [1:0]       sts_clr,
    input  logic [1:0]       ien,
    output logic [1:0]       sts,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);

    logic [1:0] sts_set;

    // Decode which status bit a miss sets
    always_comb begin
        sts_set = 2'b00;
        if (miss) sts_set = miss_write ? 2'b01 : 2'b10;
    end

    // Sticky status: clear first, then set so a new miss wins
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~sts_clr) | sts_set;
    end

    // Count missed writes
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (miss && miss_write) cnt <= cnt + 1'b1;
    end

    // Interrupt from enabled status bits
    always_comb begin
        irq = |(sts & ien);
    end

endmodule

// File: rtl/win_addr_xlate.sv
// Top of the windowed outbound address translator. Scales the incoming
// word address by the lane-dependent shift, looks it up in the window bank
// and registers a translated request one edge later; misses are dropped
// and recorded. Assumes requests are single-cycle strobes with no backpressure.
module win_addr_xlate
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned LANES   = 1,
    parameter int unsigned PRIO_W  = 2,
    parameter int unsigned DEST_W  = 16,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned SHIFT  = (LANES == 1) ? 2 : 3,
    localparam int unsigned IN_AW  = BYTE_AW - SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IN_AW-1:0]  req_addr,
    output logic              out_valid,
    output logic              out_write,
    output logic [33:3]       out_addr,
    output logic [PRIO_W-1:0] out_prio,
    output logic [DEST_W-1:0] out_dest,
    output logic [1:0]        sts_oob,
    output logic [CNT_W-1:0]  wr_miss_cnt,
    output logic              irq
);

    win_cfg_t [NUM_WIN-1:0] win;
    logic [PRIO_W-1:0]      prio;
    logic [DEST_W-1:0]      dest;
    logic [1:0]             ien;
    logic [1:0]             sts_clr;
    logic [BYTE_AW-1:0]     saddr;
    logic                   hit;
    logic [33:3]            xaddr;

    xlate_cfg_regs #(
        .NUM_WIN (NUM_WIN),
        .PRIO_W  (PRIO_W),
        .DEST_W  (DEST_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .win       (win),
        .prio      (prio),
        .dest      (dest),
        .ien       (ien),
        .sts_clr   (sts_clr)
    );

    // Word address to byte address with zero fill
    assign saddr = {req_addr, {SHIFT{1'b0}}};

    xlate_win_match #(
        .NUM_WIN (NUM_WIN)
    ) u_match (
        .win   (win),
        .saddr (saddr),
        .hit   (hit),
        .xaddr (xaddr)
    );

    xlate_miss_track #(
        .CNT_W (CNT_W)
    ) u_miss (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss       (req_valid && !hit),
        .miss_write (req_write),
        .sts_clr    (sts_clr),
        .ien        (ien),
        .sts        (sts_oob),
        .cnt        (wr_miss_cnt),
        .irq        (irq)
    );

    // Output valid: one beat per matching request
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= req_valid && hit;
    end

    // Output payload captured with the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_write <= 1'b0;
            out_addr  <= '0;
            out_prio  <= '0;
            out_dest  <= '0;
        end else if (req_valid && hit) begin
            out_write <= req_write;
            out_addr  <= xaddr;
            out_prio  <= prio;
            out_dest  <= dest;
        end
    end

endmodule

// File: rtl/xlate_chk.sv
// Temporal checks on the translator's ports, bound into every instance.
module xlate_chk
    import xlate_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_addr,
    input logic [31:0]      cfg_wdata,
    input logic             req_valid,
    input logic             req_write,
    input logic             out_valid,
    input logic [1:0]       sts_oob,
    input logic [CNT_W-1:0] wr_miss_cnt,
    input logic             irq
);

    AST_OUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid)); // R7

    AST_CNT_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_miss_cnt != $past(wr_miss_cnt)) |-> $past(req_valid && req_write)); // R11

    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_miss_cnt != $past(wr_miss_cnt)) |-> (wr_miss_cnt == $past(wr_miss_cnt) + 1'b1)); // R11

    AST_WSTS_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_oob[0]) |-> $past(req_valid && req_write)); // R8

    AST_RSTS_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_oob[1]) |-> $past(req_valid && !req_write)); // R8

    AST_WSTS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_oob[0]) |-> $past(cfg_we && cfg_addr == STS_ADDR && cfg_wdata[0])); // R10

    AST_RSTS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_oob[1]) |-> $past(cfg_we && cfg_addr == STS_ADDR && cfg_wdata[1])); // R10

    AST_IRQ_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_oob != 2'b00)); // R9

endmodule

bind win_addr_xlate xlate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .out_valid   (out_valid),
    .sts_oob     (sts_oob),
    .wr_miss_cnt (wr_miss_cnt),
    .irq         (irq)
);

// File: tb/win_addr_xlate_bench.sv
module win_addr_xlate_bench;

    localparam int NW    = 4;
    localparam int SH    = 2;     // LANES = 1
    localparam int IAW   = 32 - SH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [IAW-1:0]    req_addr = '0;
    logic              out_valid, out_write, irq;
    logic [33:3]       out_addr;
    logic [1:0]        out_prio, sts_oob;
    logic [15:0]       out_dest, wr_miss_cnt;

    int total = 0;
    int bad   = 0;

    // Reference state kept from the requirements
    logic [31:0] m_base [NW];
    logic [31:0] m_mask [NW];
    logic [31:0] m_off  [NW];
    logic        m_en   [NW];
    logic [1:0]  m_prio;
    logic [15:0] m_dest;
    logic [1:0]  m_sts, m_ien;
    logic [15:0] m_cnt;

    always #2 clk = ~clk;

    win_addr_xlate #(.NUM_WIN(NW), .LANES(1)) u_win_addr_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .out_valid(out_valid), .out_write(out_write),
        .out_addr(out_addr), .out_prio(out_prio), .out_dest(out_dest),
        .sts_oob(sts_oob), .wr_miss_cnt(wr_miss_cnt), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 8'(4*NW)) begin
            case (a[1:0])
                2'd0: m_base[a[7:2]] = d;
                2'd1: m_mask[a[7:2]] = d;
                2'd2: m_off[a[7:2]]  = d;
                default: m_en[a[7:2]] = d[0];
            endcase
        end else if (a == 8'h80) begin
            m_prio = d[1:0]; m_dest = d[31:16];
        end else if (a == 8'h81) begin
            m_sts = m_sts & ~d[1:0];
        end else if (a == 8'h82) begin
            m_ien = d[1:0];
        end
    endtask

    // Drive one request, then compare everything it should have produced
    task automatic send(input logic [IAW-1:0] a, input logic wr);
        logic [31:0] s;
        logic        hit;
        logic [33:3] exp_a;
        s = {a, 2'b00};
        hit = 1'b0; exp_a = '0;
        for (int w = 0; w < NW; w++) begin
            logic [31:0] mk;
            mk = {m_mask[w][31:3], 3'b000};
            if (!hit && m_en[w] && ((s & mk) == ({m_base[w][31:3], 3'b000} & mk))) begin
                hit = 1'b1;
                exp_a = {m_off[w][1:0], (m_off[w][31:3] & m_mask[w][31:3]) | s[31:3]};
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!hit) begin
            m_sts = m_sts | (wr ? 2'b01 : 2'b10);
            if (wr) m_cnt = m_cnt + 16'd1;
        end
        check("R2/R8 out_valid", 64'(out_valid), 64'(hit));
        if (hit) begin
            check("R3/R4/R5 out_addr", 64'(out_addr), 64'(exp_a));
            check("R6 prio/dest", 64'({out_prio, out_dest}), 64'({m_prio, m_dest}));
            check("R7 out_write", 64'(out_write), 64'(wr));
        end
        check("R8/R10 sts_oob", 64'(sts_oob), 64'(m_sts));
        check("R11 wr_miss_cnt", 64'(wr_miss_cnt), 64'(m_cnt));
        check("R9 irq", 64'(irq), 64'(|(m_sts & m_ien)));
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_base[w] = '0; m_mask[w] = '0; m_off[w] = '0; m_en[w] = 1'b0;
        end
        m_prio = '0; m_dest = '0; m_sts = '0; m_ien = '0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 sts_oob", 64'(sts_oob), 64'd0);
        check("R1 wr_miss_cnt", 64'(wr_miss_cnt), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        // R1/R2: unconfigured windows never match
        send(30'h0400_0000, 1'b1);
        send(30'h0000_0000, 1'b0);
        cfg_write(8'h81, 32'h3);
        check("R10 clear both", 64'(sts_oob), 64'd0);

        // Overlapping windows, one disabled, junk in low bits (R3, R5)
        cfg_write(8'h80, 32'hBEEF_0002);
        cfg_write(8'd0,  32'h1000_0000); cfg_write(8'd1, 32'hF000_0000);
        cfg_write(8'd2,  32'h5000_0003); cfg_write(8'd3, 32'h1);
        cfg_write(8'd4,  32'h1000_0007); cfg_write(8'd5, 32'hF800_0000);
        cfg_write(8'd6,  32'hC000_0001); cfg_write(8'd7, 32'h1);
        cfg_write(8'd8,  32'h2000_0000); cfg_write(8'd9, 32'hE000_0000);
        cfg_write(8'd10, 32'h4000_0002); cfg_write(8'd11, 32'h0);
        cfg_write(8'd12, 32'h8000_0005); cfg_write(8'd13, 32'h8000_0007);
        cfg_write(8'd14, 32'hF400_0006); cfg_write(8'd15, 32'h1);

        for (int i = 0; i < 256; i++) begin
            send({i[7:0], 22'(i * 32'h9E37)}, i[0]);
        end

        // Enable window 2, interrupts on, new pattern and control values
        cfg_write(8'd11, 32'h1);
        cfg_write(8'h82, 32'h3);
        cfg_write(8'h80, 32'h1234_0001);
        for (int i = 0; i < 256; i++) begin
            send({8'(i * 5), 22'(i * 32'h3C1 + 7)}, ~i[1]);
        end

        // R10: clear write bit only, read bit stays
        cfg_write(8'h81, 32'h1);
        check("R10 w1c bit0", 64'(sts_oob), 64'(m_sts));
        cfg_write(8'h81, 32'h0);
        check("R10 write zero", 64'(sts_oob), 64'(m_sts));
        // R9: gating by the enable bits
        cfg_write(8'h82, 32'h1);
        check("R9 irq gated", 64'(irq), 64'(|(m_sts & m_ien)));
        cfg_write(8'h82, 32'h2);
        check("R9 irq read en", 64'(irq), 64'(|(m_sts & m_ien)));
        cfg_write(8'h81, 32'h3);
        check("R9 irq after clear", 64'(irq), 64'd0);

        // R10: clear and new write miss on the same edge, set wins
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h81; cfg_wdata = 32'h1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = '0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_sts = 2'b01; m_cnt = m_cnt + 16'd1;
        check("R10 set wins", 64'(sts_oob), 64'(m_sts));
        check("R11 cnt on collide", 64'(wr_miss_cnt), 64'(m_cnt));
        check("R8 no beat on miss", 64'(out_valid), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule